// File: doc/BRIEF.md
# Serial-Loaded Control Register Bank

This block is a write-only, three-wire serial slave that fills a bank of control registers. A host holds the select line low, clocks words in one bit per serial clock rising edge, and raises the select line to commit the word. Each full word holds 18 bits: 14 data bits followed by a 4-bit register address, sent most significant bit first. All register contents are driven in parallel on one flat output bus, so the logic that uses the settings can read them without any handshake.

The serial select, clock and data pins are brought into the system clock domain through two-flop synchronisers. Their edges are then detected on the system clock, so the system clock must run at least four times faster than the serial clock. The shift register keeps only the newest 18 bits, and the frame length is not checked. A host can therefore send only the low data bits it needs plus the address. The remaining upper data bits are whatever older bits are still in the shift register.

Top module: `ser_reg_bank`

## Requirements
- R1: A synchronous reset loads every register with its parameter default and clears the shift register, so the first frame after reset shifts zeros into any data bits it does not supply.
- R2: Each serial clock rising edge seen while select is low shifts exactly one bit into the shift register, MSB first. For an 18-bit frame, bits [17:4] are the data and bits [3:0] are the address.
- R3: Serial clock edges that occur while select is high do not change the shift register.
- R4: A register changes only when select goes from low to high. While select is low, or when select stays high, every register holds its value.
- R5: A frame longer than 18 bits commits only its last 18 bits.
- R6: A frame shorter than 18 bits commits a word whose upper bits are the older bits already in the shift register, moved up by the number of bits received.
- R7: A commit to address 13, 14 or 15 leaves every register unchanged.
- R8: A commit to a valid address 0 to 12 changes only the register at that address. Register k appears at regBank[14k+13:14k].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| csN | input | 1 | Serial select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous, sampled on its rising edge |
| sdi | input | 1 | Serial data in |
| regBank | output | 182 | All 13 registers, 14 bits each, register k at [14k+13:14k] |

## Verification
The bench writes every one of the 16 addresses with a distinct computed value and compares all 13 registers against a bench model after each commit. A decoder that aliased addresses 13 to 15 onto real registers, or that wrote more than one register, would show up at once. Frames of 4, 8 and 26 bits check how the shift register carries bits over between frames: a design that cleared the shift register between frames, kept the oldest bits of a long frame, or miscounted edges would commit the wrong data. Serial clock pulses sent while deselected, and checks of the bank in the middle of a frame, catch designs that shift while idle or write before select rises.

// File: rtl/srb_pkg.sv
`timescale 1ns/1ps
package srb_pkg;
  // Control strobes handed from the edge-detect logic to the datapath.
  typedef struct packed {
    logic shiftEn;   // one-cycle pulse: take shiftBit into the word
    logic shiftBit;  // synchronised serial data
    logic commit;    // one-cycle pulse: select released
  } strobe_t;
endpackage

// File: rtl/srb_ctrl.sv
`timescale 1ns/1ps
module srb_ctrl
  import srb_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    csN,
  input  logic    sclk,
  input  logic    sdi,
  output strobe_t strobes
);
  localparam int TOP = SYNC_DEPTH - 1;

  logic [SYNC_DEPTH-1:0] csPipe, sclkPipe, sdiPipe;
  logic csLast, sclkLast;

  always_ff @(posedge clk) begin
    if (rst) begin
      csPipe   <= '1;
      sclkPipe <= '0;
      sdiPipe  <= '0;
      csLast   <= 1'b1;
      sclkLast <= 1'b0;
    end else begin
      csPipe   <= {csPipe[TOP-1:0], csN};
      sclkPipe <= {sclkPipe[TOP-1:0], sclk};
      sdiPipe  <= {sdiPipe[TOP-1:0], sdi};
      csLast   <= csPipe[TOP];
      sclkLast <= sclkPipe[TOP];
    end
  end

  always_comb begin
    strobes.shiftEn  = sclkPipe[TOP] & ~sclkLast & ~csPipe[TOP];
    strobes.shiftBit = sdiPipe[TOP];
    strobes.commit   = csPipe[TOP] & ~csLast;
  end
endmodule

// File: rtl/srb_datapath.sv
`timescale 1ns/1ps
module srb_datapath
  import srb_pkg::*;
#(
  parameter int NUM_REGS = 13,
  parameter int DATA_W   = 14,
  parameter int ADDR_W   = 4,
  parameter logic [NUM_REGS*DATA_W-1:0] RESET_VALS = '0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  strobe_t                    strobes,
  output logic [NUM_REGS*DATA_W-1:0] regBank
);
  localparam int WORD_W = DATA_W + ADDR_W;

  logic [WORD_W-1:0] shiftWord;
  logic [ADDR_W-1:0] tgtAddr;
  logic [DATA_W-1:0] tgtData;

  assign tgtAddr = shiftWord[ADDR_W-1:0];
  assign tgtData = shiftWord[WORD_W-1:ADDR_W];

  always_ff @(posedge clk) begin
    if (rst)
      shiftWord <= '0;
    else if (strobes.shiftEn)
      shiftWord <= {shiftWord[WORD_W-2:0], strobes.shiftBit};
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DATA_W-1:0] val;
    logic hit;
    assign hit = strobes.commit && (tgtAddr == ADDR_W'(g));
    always_ff @(posedge clk) begin
      if (rst)
        val <= RESET_VALS[g*DATA_W +: DATA_W];
      else if (hit)
        val <= tgtData;
    end
    assign regBank[g*DATA_W +: DATA_W] = val;
  end
endmodule

// File: rtl/ser_reg_bank.sv
`timescale 1ns/1ps
module ser_reg_bank
  import srb_pkg::*;
#(
  parameter int NUM_REGS   = 13,
  parameter int DATA_W     = 14,
  parameter int ADDR_W     = 4,
  parameter int SYNC_DEPTH = 2,
  parameter logic [NUM_REGS*DATA_W-1:0] RESET_VALS = {
    14'h007F, 14'h0000, 14'h03C0, 14'h0022, 14'h0003, 14'h0000, 14'h1C00,
    14'h1824, 14'h3333, 14'h30A2, 14'h1007, 14'h3000, 14'h1140}
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       csN,
  input  logic                       sclk,
  input  logic                       sdi,
  output logic [NUM_REGS*DATA_W-1:0] regBank
);
  strobe_t strobes;

  srb_ctrl #(.SYNC_DEPTH(SYNC_DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .csN(csN), .sclk(sclk), .sdi(sdi), .strobes(strobes)
  );

  srb_datapath #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RESET_VALS(RESET_VALS)
  ) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .regBank(regBank)
  );
endmodule

// File: rtl/srb_checker.sv
`timescale 1ns/1ps
module srb_checker
  import srb_pkg::*;
#(
  parameter int NUM_REGS   = 13,
  parameter int DATA_W     = 14,
  parameter int ADDR_W     = 4,
  parameter int SYNC_DEPTH = 2,
  parameter logic [NUM_REGS*DATA_W-1:0] RESET_VALS = '0
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       csN,
  input strobe_t                    strobes,
  input logic [DATA_W+ADDR_W-1:0]   shiftWord,
  input logic [NUM_REGS*DATA_W-1:0] regBank
);
  logic [SYNC_DEPTH-1:0]      csDly;
  logic [NUM_REGS*DATA_W-1:0] prevBank;
  logic [NUM_REGS-1:0]        chg;

  always_ff @(posedge clk) begin
    if (rst) begin
      csDly    <= '1;
      prevBank <= RESET_VALS;
    end else begin
      csDly    <= {csDly[SYNC_DEPTH-2:0], csN};
      prevBank <= regBank;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_chg
    assign chg[g] = regBank[g*DATA_W +: DATA_W] != prevBank[g*DATA_W +: DATA_W];
  end

  p_reset_defaults_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> regBank == RESET_VALS);

  p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    strobes.shiftEn |=> !strobes.shiftEn);

  p_no_shift_deselected_r3: assert property (@(posedge clk) disable iff (rst)
    csDly[SYNC_DEPTH-1] |-> !strobes.shiftEn);

  p_hold_without_commit_r4: assert property (@(posedge clk) disable iff (rst)
    !strobes.commit |=> $stable(regBank));

  p_bad_addr_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (strobes.commit && shiftWord[ADDR_W-1:0] >= ADDR_W'(NUM_REGS)) |=> $stable(regBank));

  p_one_reg_changes_r8: assert property (@(posedge clk) disable iff (rst)
    $countones(chg) <= 1);
endmodule

bind ser_reg_bank srb_checker #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .SYNC_DEPTH(SYNC_DEPTH), .RESET_VALS(RESET_VALS)
) u_srbChk (
  .clk(clk), .rst(rst), .csN(csN), .strobes(strobes),
  .shiftWord(u_dp.shiftWord), .regBank(regBank)
);

// File: tb/test_ser_reg_bank.sv
`timescale 1ns/1ps
module test_ser_reg_bank;
  localparam int NR = 13;
  localparam int DW = 14;
  localparam int AW = 4;
  localparam int WW = DW + AW;

  function automatic logic [NR*DW-1:0] mkDef();
    logic [NR*DW-1:0] v;
    for (int i = 0; i < NR; i++) v[i*DW +: DW] = DW'((i * 32'h0A53 + 32'h0111) & 32'h3FFF);
    return v;
  endfunction
  localparam logic [NR*DW-1:0] DEFS = mkDef();

  logic clk = 1'b0, rst = 1'b1, csN = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [NR*DW-1:0] regBank;
  int total = 0, bad = 0;
  bit done = 1'b0;

  logic [WW-1:0] mSh;
  logic [DW-1:0] mBank [NR];

  always #4 clk = ~clk;

  ser_reg_bank #(.NUM_REGS(NR), .DATA_W(DW), .ADDR_W(AW), .RESET_VALS(DEFS)) i_ser_reg_bank (
    .clk(clk), .rst(rst), .csN(csN), .sclk(sclk), .sdi(sdi), .regBank(regBank)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseBit(logic b);
    sdi = b; tick(2);
    sclk = 1'b1; tick(4);
    sclk = 1'b0; tick(2);
  endtask

  task automatic checkBank(string tag);
    for (int i = 0; i < NR; i++) begin
      total++;
      if (regBank[i*DW +: DW] !== mBank[i]) begin
        bad++;
        $display("FAIL %s reg%0d got=%h exp=%h", tag, i, regBank[i*DW +: DW], mBank[i]);
      end
    end
  endtask

  // Shift n bits of val (MSB first) in one frame, then release select.
  task automatic frame(logic [31:0] val, int n, bit midCheck, string tag);
    csN = 1'b0; tick(4);
    for (int i = n - 1; i >= 0; i--) begin
      pulseBit(val[i]);
      mSh = {mSh[WW-2:0], val[i]};
    end
    tick(4);
    if (midCheck) checkBank("R4 bank held while select low");
    csN = 1'b1; tick(8);
    if (mSh[AW-1:0] < NR) mBank[mSh[AW-1:0]] = mSh[WW-1:AW];
    checkBank(tag);
  endtask

  initial begin
    mSh = '0;
    for (int i = 0; i < NR; i++) mBank[i] = DEFS[i*DW +: DW];
    tick(6);
    rst = 1'b0;
    tick(2);
    checkBank("R1 reset defaults");

    // Address-only frame: data bits come from a cleared shift register.
    frame(32'h2, 4, 1'b0, "R1 R6 cleared shift register");

    // Full frames to all 16 addresses.
    for (int a = 0; a < 16; a++) begin
      logic [DW-1:0] d;
      d = DW'((a * 32'h1357 + 32'h02A5) & 32'h3FFF);
      frame({14'b0, d, AW'(a)}, WW, 1'b1, "R2 R7 R8 full frame sweep");
    end

    // Over-long frame: 8 leading junk bits dropped.
    frame({6'b0, 8'hA5, 14'h2B6D, 4'd7}, 26, 1'b0, "R5 long frame keeps last bits");
    frame({6'b0, 8'h5A, 14'h0F0F, 4'd12}, 26, 1'b0, "R5 long frame to last register");

    // Short frames: 4 data bits + address.
    for (int a = 0; a < NR; a++)
      frame({24'b0, 4'(a + 3), AW'(a)}, 8, 1'b0, "R6 short frame carry-over");

    // Serial clocks while deselected must not shift.
    for (int i = 0; i < 6; i++) pulseBit(1'b1);
    frame(32'h9, 4, 1'b0, "R3 clocks ignored while deselected");
    for (int i = 0; i < 6; i++) pulseBit(i[0]);
    frame(32'hD, 4, 1'b0, "R3 R7 deselected clocks then bad address");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule